// File: doc/BRIEF.md
# Signal History and Override Probe

This block sits in series with one signal of a user design. In each user cycle, marked by the user clock enable, it stores the value it drives downstream into a circular history buffer. A debug host talks to it through a small command port with one command per cycle and a registered response one cycle later. Through that port the host can:

- read the live value;
- read any recorded value, addressed as a distance back from the most recent one;
- force a value of its own onto the downstream side, either for a single user cycle or until it releases the force;
- roll the recorded history back by a number of user cycles.

A rollback moves the buffer's write position back and shrinks the count of valid entries. The value stored at the new position is then replayed downstream until the next user cycle. That cycle stores the replayed value again at the same position, and normal capture resumes. A rollback can never reach further back than the history that is actually held.

Top module: `dbg_var_trace`

## Requirements
- R1: After reset the downstream value equals the upstream value, no response is valid, and a history read at offset 0 is refused with the error flag.
- R2: With no force and no replay pending, var_out equals var_in in the same cycle.
- R3: On every clock edge where user_ce is 1 and no accepted rollback is issued, the value on var_out is stored as the newest history entry. Edges with user_ce at 0 store nothing.
- R4: Command code 1 (history read) returns the entry cmd_arg places back from the newest, where offset 0 is the newest. An offset not below the valid count returns data 0 with rsp_err set.
- R5: The valid count grows by one per stored entry and saturates at DEPTH. Once the buffer is full, each new store replaces the oldest entry.
- R6: Command code 0 returns in rsp_data the var_out value present in the cycle the command was issued.
- R7: Command code 2 (single force) drives cmd_wdata onto var_out from the next cycle up to and including the next cycle with user_ce at 1. After that cycle, var_out no longer shows the forced value.
- R8: Command code 3 (held force) drives cmd_wdata onto var_out until command code 4 (release). Code 4 also cancels a pending single force. Codes 2 and 3 each replace the other.
- R9: Command code 5 (rollback by n = cmd_arg) with 1 <= n <= valid count moves the write position back by n and reduces the count by n. It drives the entry recorded n stores ago onto var_out until the next user_ce cycle, and no store happens on the edge that takes it. If n exceeds the count, rsp_err is set and nothing changes. n = 0 is accepted and does nothing.
- R10: rsp_valid is 1 exactly in the cycle after a cycle with cmd_valid at 1. Codes 6 and 7 return rsp_err set and data 0. Codes 2, 3 and 4 return rsp_err clear and data 0.
- R11: On var_out, a held force outranks a single force, which outranks a rollback replay, which outranks var_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_ce | input | 1 | User clock enable; marks a user cycle |
| var_in | input | DATA_W | Signal value from the producing user logic |
| var_out | output | DATA_W | Signal value seen by downstream user logic |
| cmd_valid | input | 1 | Host command present this cycle |
| cmd_op | input | 3 | Host command code (0 to 7) |
| cmd_arg | input | AW+1 | History offset or rollback distance |
| cmd_wdata | input | DATA_W | Force value |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DATA_W | Response value |
| rsp_err | output | 1 | Command refused |

## Verification
A corrupted write position or valid count does not show until the host asks. It then appears as wrong data or a wrong error flag on the next history read or rollback response, one cycle after the command. A mistake in the source selection state shows at once on var_out, in the same cycle. A replayed value that is stored at the wrong slot shows up several cycles later, as a mismatch in a history read. For this reason the random phase mixes history reads at many offsets with rollbacks and forces across long runs, including runs that wrap the buffer.

// File: rtl/dvt_pkg.sv
package dvt_pkg;
  typedef enum logic [2:0] {
    OP_RD_CUR   = 3'd0,
    OP_RD_HIST  = 3'd1,
    OP_FORCE_1  = 3'd2,
    OP_FORCE_H  = 3'd3,
    OP_RELEASE  = 3'd4,
    OP_REWIND   = 3'd5
  } dvt_op_e;
endpackage

// File: rtl/dvt_hist_buf.sv
module dvt_hist_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rw_en,
  input  logic [CW-1:0]     rw_n,
  input  logic [AW-1:0]     rd_off,
  output logic [DATA_W-1:0] rd_hist,
  output logic [DATA_W-1:0] rd_rw,
  output logic [CW-1:0]     count
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [AW-1:0]     hist_idx, rw_idx;

  assign hist_idx = wptr_q - AW'(1) - rd_off;
  assign rw_idx   = wptr_q - rw_n[AW-1:0];
  assign rd_hist  = mem_q[hist_idx];
  assign rd_rw    = mem_q[rw_idx];
  assign count    = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    if (rw_en) begin
      wptr_d = rw_idx;
      cnt_d  = cnt_q - rw_n;
    end else if (wr_en) begin
      wptr_d = wptr_q + AW'(1);
      if (cnt_q != CW'(DEPTH)) cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rw_en) mem_q[wptr_q] <= wr_data;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rw_en && cnt_q != CW'(DEPTH)) |=> cnt_q == $past(cnt_q) + CW'(1)); // R5
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rw_en) |=> wptr_q == $past(wptr_q) + AW'(1)); // R3
  AST_REWIND_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    rw_en |=> cnt_q == $past(cnt_q) - $past(rw_n)); // R9
endmodule

// File: rtl/dvt_src_sel.sv
module dvt_src_sel #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_ce,
  input  logic [DATA_W-1:0] var_in,
  input  logic              set_once,
  input  logic              set_hold,
  input  logic              release_f,
  input  logic [DATA_W-1:0] force_data,
  input  logic              rw_go,
  input  logic [DATA_W-1:0] rw_val,
  output logic [DATA_W-1:0] var_out
);
  logic              hold_q, hold_d;
  logic              once_q, once_d;
  logic              rep_q, rep_d;
  logic [DATA_W-1:0] fval_q, fval_d;
  logic [DATA_W-1:0] rval_q, rval_d;

  always_comb begin
    if (hold_q)      var_out = fval_q;
    else if (once_q) var_out = fval_q;
    else if (rep_q)  var_out = rval_q;
    else             var_out = var_in;
  end

  always_comb begin
    hold_d = hold_q;
    once_d = once_q;
    rep_d  = rep_q;
    fval_d = fval_q;
    rval_d = rval_q;
    if (user_ce && !rw_go) begin
      once_d = 1'b0;
      rep_d  = 1'b0;
    end
    if (rw_go) begin
      rep_d  = 1'b1;
      rval_d = rw_val;
    end
    if (release_f) begin
      hold_d = 1'b0;
      once_d = 1'b0;
    end else if (set_hold) begin
      hold_d = 1'b1;
      once_d = 1'b0;
      fval_d = force_data;
    end else if (set_once) begin
      once_d = 1'b1;
      hold_d = 1'b0;
      fval_d = force_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      once_q <= 1'b0;
      rep_q  <= 1'b0;
      fval_q <= '0;
      rval_q <= '0;
    end else begin
      hold_q <= hold_d;
      once_q <= once_d;
      rep_q  <= rep_d;
      fval_q <= fval_d;
      rval_q <= rval_d;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q) && !$past(set_hold)) |-> $stable(var_out)); // R8
  AST_ONCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (once_q && user_ce && !rw_go && !set_once && !set_hold) |=> !once_q); // R7
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    release_f |=> !hold_q && !once_q); // R8
endmodule

// File: rtl/dvt_host_port.sv
module dvt_host_port #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [CW-1:0]     cmd_arg,
  input  logic [CW-1:0]     count,
  input  logic [DATA_W-1:0] cur_val,
  input  logic [DATA_W-1:0] hist_val,
  output logic              set_once,
  output logic              set_hold,
  output logic              release_f,
  output logic              rw_go,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  import dvt_pkg::*;

  dvt_op_e           op;
  logic              rsp_valid_d, rsp_err_d;
  logic [DATA_W-1:0] rsp_data_d;

  assign op        = dvt_op_e'(cmd_op);
  assign set_once  = cmd_valid && op == OP_FORCE_1;
  assign set_hold  = cmd_valid && op == OP_FORCE_H;
  assign release_f = cmd_valid && op == OP_RELEASE;
  assign rw_go     = cmd_valid && op == OP_REWIND && cmd_arg != '0 && cmd_arg <= count;

  always_comb begin
    rsp_valid_d = cmd_valid;
    rsp_data_d  = '0;
    rsp_err_d   = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_RD_CUR:  rsp_data_d = cur_val;
        OP_RD_HIST: begin
          if (cmd_arg < count) rsp_data_d = hist_val;
          else                 rsp_err_d  = 1'b1;
        end
        OP_REWIND:  rsp_err_d = cmd_arg > count;
        OP_FORCE_1, OP_FORCE_H, OP_RELEASE: rsp_err_d = 1'b0;
        default:    rsp_err_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_data  <= rsp_data_d;
      rsp_err   <= rsp_err_d;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid); // R10
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid); // R10
  AST_HIST_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && cmd_arg >= count) |=> rsp_err && rsp_data == '0); // R4
endmodule

// File: rtl/dbg_var_trace.sv
module dbg_var_trace #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_ce,
  input  logic [DATA_W-1:0] var_in,
  output logic [DATA_W-1:0] var_out,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [CW-1:0]     cmd_arg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  logic              set_once, set_hold, release_f, rw_go;
  logic [CW-1:0]     count;
  logic [DATA_W-1:0] hist_val, rw_val;
  logic              wr_en;

  assign wr_en = user_ce && !rw_go;

  dvt_hist_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(var_out),
    .rw_en(rw_go), .rw_n(cmd_arg), .rd_off(cmd_arg[AW-1:0]),
    .rd_hist(hist_val), .rd_rw(rw_val), .count(count)
  );

  dvt_src_sel #(.DATA_W(DATA_W)) u_src (
    .clk(clk), .rst_n(rst_n), .user_ce(user_ce), .var_in(var_in),
    .set_once(set_once), .set_hold(set_hold), .release_f(release_f),
    .force_data(cmd_wdata), .rw_go(rw_go), .rw_val(rw_val), .var_out(var_out)
  );

  dvt_host_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_host (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .count(count), .cur_val(var_out), .hist_val(hist_val),
    .set_once(set_once), .set_hold(set_hold), .release_f(release_f),
    .rw_go(rw_go), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );
endmodule

// File: tb/dbg_var_trace_tb_top.sv
module dbg_var_trace_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int DEPTH = 256;
  localparam int CW = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic user_ce;
  logic [DW-1:0] var_in, var_out, cmd_wdata, rsp_data;
  logic cmd_valid, rsp_valid, rsp_err;
  logic [2:0] cmd_op;
  logic [CW-1:0] cmd_arg;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  logic [DW-1:0] mh [DEPTH];
  int mw, mc;
  bit m_hold, m_once, m_rep;
  logic [DW-1:0] m_fv, m_rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_var_trace #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .user_ce(user_ce), .var_in(var_in), .var_out(var_out),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] exp_out(logic [DW-1:0] vin);
    if (m_hold) return m_fv;
    if (m_once) return m_fv;
    if (m_rep) return m_rv;
    return vin;
  endfunction

  function automatic string op_req(int op);
    case (op)
      0: return "R6";
      1: return "R4";
      2: return "R7";
      3, 4: return "R8";
      5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic step(bit ce, logic [DW-1:0] vin, bit cv, int op, int arg, logic [DW-1:0] wd);
    logic [DW-1:0] eo, ed;
    bit ee, rw;
    @(negedge clk);
    user_ce = ce; var_in = vin; cmd_valid = cv;
    cmd_op = 3'(op); cmd_arg = CW'(arg); cmd_wdata = wd;
    #1;
    eo = exp_out(vin);
    if (!m_hold && !m_once && !m_rep) chk("R2", var_out, eo);
    else chk("R11", var_out, eo);
    ed = '0; ee = 0;
    if (cv) begin
      case (op)
        0: ed = eo;
        1: if (arg < mc) ed = mh[(mw - 1 - arg) & (DEPTH-1)]; else ee = 1;
        5: ee = (arg > mc);
        2, 3, 4: ee = 0;
        default: ee = 1;
      endcase
    end
    rw = cv && op == 5 && arg != 0 && arg <= mc;
    if (ce && !rw) begin
      mh[mw] = eo; mw = (mw + 1) % DEPTH;
      if (mc < DEPTH) mc++;
      m_once = 0; m_rep = 0;
    end
    if (rw) begin
      mw = (mw - arg) & (DEPTH-1); mc -= arg; m_rep = 1; m_rv = mh[mw];
    end
    if (cv && op == 4) begin m_hold = 0; m_once = 0; end
    else if (cv && op == 3) begin m_hold = 1; m_once = 0; m_fv = wd; end
    else if (cv && op == 2) begin m_once = 1; m_hold = 0; m_fv = wd; end
    @(posedge clk); #1;
    chk("R10", {31'd0, rsp_valid}, {31'd0, cv});
    if (cv) begin
      chk(op_req(op), rsp_data, ed);
      chk(op_req(op), {31'd0, rsp_err}, {31'd0, ee});
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; user_ce = 0; var_in = 16'h1234; cmd_valid = 0;
    cmd_op = 0; cmd_arg = 0; cmd_wdata = 0;
    mw = 0; mc = 0; m_hold = 0; m_once = 0; m_rep = 0; m_fv = 0; m_rv = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", var_out, 16'h1234);
    chk("R1", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk); rst_n = 1;
    step(0, 16'h0055, 1, 1, 0, 0);              // R1 empty history refused
    // R3 capture with gaps
    for (int i = 0; i < 12; i++) step(i % 3 != 0, 16'(100 + i), 0, 0, 0, 0);
    for (int k = 0; k < 9; k++) step(0, 16'h0, 1, 1, k, 0);   // R4 reads
    step(0, 16'h0, 1, 1, 8, 0);                 // R4 beyond count
    step(1, 16'h0200, 1, 0, 0, 0);              // R6
    // R9 rollback and replay
    step(0, 16'h0300, 1, 5, 3, 0);
    step(0, 16'h0301, 0, 0, 0, 0);
    step(1, 16'h0302, 0, 0, 0, 0);
    step(1, 16'h0303, 1, 5, 0, 0);              // n=0
    step(0, 16'h0304, 1, 5, 200, 0);            // too far
    step(1, 16'h0305, 1, 5, 2, 0);              // rollback with ce
    // R7 single force
    step(0, 16'h0400, 1, 2, 0, 16'hBEEF);
    step(0, 16'h0401, 0, 0, 0, 0);
    step(1, 16'h0402, 0, 0, 0, 0);
    step(1, 16'h0403, 0, 0, 0, 0);
    // R8 held force, R11 priority
    step(1, 16'h0500, 1, 3, 0, 16'hCAFE);
    step(1, 16'h0501, 1, 5, 1, 0);
    step(1, 16'h0502, 1, 2, 0, 16'hF00D);
    step(0, 16'h0503, 1, 3, 0, 16'hCAFE);
    step(1, 16'h0504, 1, 4, 0, 0);
    step(1, 16'h0505, 1, 6, 0, 0);              // R10 bad code
    step(1, 16'h0506, 1, 7, 0, 0);
    // R5 wrap and saturate
    for (int i = 0; i < 300; i++) step(1, 16'(i * 7 + 3), 0, 0, 0, 0);
    step(0, 16'h0, 1, 1, 255, 0);
    step(0, 16'h0, 1, 1, 256, 0);
    step(0, 16'h0, 1, 5, 257, 0);
    step(0, 16'h0, 1, 5, 256, 0);
    step(1, 16'h0777, 1, 1, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op, arg, r;
      r = $urandom_range(0, 99);
      op = $urandom_range(0, 7);
      if (op == 3 && $urandom_range(0, 3) != 0) op = 4;
      if (op == 5) arg = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 300) : $urandom_range(0, 12);
      else arg = $urandom_range(0, mc + 3);
      step($urandom_range(0, 3) != 0, 16'($urandom), r < 40, op, arg, 16'($urandom));
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule